// File: doc/BRIEF.md
# Register-Mapped Byte Packet Port

This block is a minimal network adapter that sits on a 32-bit register bus. It holds one received frame and one outgoing frame, each in its own byte buffer. Frames come in and go out as byte streams with valid, ready and last. The host moves payload one byte per register access through two data ports. It reads each received byte from the receive port, which advances an internal read pointer. It writes each transmit byte to the transmit port. A frame goes out by itself once the number of written bytes reaches a preset length.

A single level interrupt reflects a small interrupt-control register. That register holds a transmit-done flag, a receive-done flag and a self-test flag. Writes to it clear flags in a fixed priority, or start a soft reset. A busy flag gates the acceptance of new frames. The host clears busy by acknowledging the interrupt. Every incoming frame is accepted, with no address filtering and no CRC handling.

Stream rules: on both streams a byte moves on a clock edge where valid and ready are both high. The block never drops valid on its output stream, or changes the byte or last, until ready is seen. On the input side, ready is low while a new frame cannot be taken, so the source waits. Once a frame has been judged too long, ready stays high until that frame's last byte, so the source never stalls.

Top module: `byte_pkt_port`

## Requirements
- R1: Only address bits 5:0 are decoded, so 0x40 aliases 0x00. Offset 0x00 reads 0x504B5450 and 0x04 reads 0x4F525430. Offset 0x18 and every unmapped offset read 0. Writes to read-only and unmapped offsets change nothing.
- R2: After reset, busy (offset 0x08, bit 0) reads 1. The receive count (0x0C), the transmit count (0x10) and interrupt control (0x14) read 0, and irq is low.
- R3: Interrupt control holds transmit-done at bit 0, receive-done at bit 1 and test at bit 31. irq is high exactly when any of these bits is set.
- R4: A read of interrupt control returns its current value, then clears the test bit. The read leaves busy unchanged.
- R5: A write to interrupt control acts on one bit only, by priority. Write bit 0 set clears transmit-done only. Otherwise, write bit 1 set clears receive-done only. Otherwise, write bit 31 set starts a soft reset. A write of 0 clears nothing. After the write, busy equals the OR of the interrupt-control bits.
- R6: A soft reset has the effects of reset and leaves only the test bit set. An incoming frame in progress at that moment is discarded.
- R7: A new incoming frame is taken only when busy is 0; otherwise rx_ready stays low. When a frame of L < 1514 bytes completes, the receive count becomes L, busy becomes 1 and receive-done is set.
- R8: A frame of 1514 bytes or more is dropped. It is drained with rx_ready high and changes no register.
- R9: A read of offset 0x1C with a nonzero receive count returns the next byte in bits 7:0, with upper bits 0, and decrements the count by one. With a count of 0 the read returns 0 and changes nothing.
- R10: A write to the transmit count stores the value when it is at most 1514, and 0 otherwise. Either write rewinds the transmit write pointer.
- R11: A write to offset 0x20 stores bits 7:0 and advances the pointer. When the pointer equals the stored count, or reaches 1514, a frame of that length is sent. The count then reads 0, transmit-done is set and busy becomes 1. With a count of 0, a frame is sent only after 1514 bytes.
- R12: The outgoing frame holds its byte and last stable while tx_valid is high and tx_ready is low. tx_last marks the final byte. Writes to offset 0x20 are ignored while a frame is still leaving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; ignored when bus_wr is also high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Incoming byte accepted |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink takes outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench samples bus_rdata in the same cycle as the read strobe. A read's side effect, such as a count decrement or the clearing of the test bit, shows on the next access. A write, including one that triggers a transmit, takes effect at its clock edge. The count and interrupt registers and irq therefore show the new value in the following cycle, and tx_valid rises one cycle after the final data write. A received frame updates the count, busy and irq at the edge that takes its last byte. The bench samples all of these one time unit after an edge, or midway between edges.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  parameter int FRAME_MAX_DEF = 1514;

  localparam logic [5:0] OFF_ID0   = 6'h00;
  localparam logic [5:0] OFF_ID1   = 6'h04;
  localparam logic [5:0] OFF_BUSY  = 6'h08;
  localparam logic [5:0] OFF_RXCNT = 6'h0C;
  localparam logic [5:0] OFF_TXCNT = 6'h10;
  localparam logic [5:0] OFF_ICTL  = 6'h14;
  localparam logic [5:0] OFF_INFO  = 6'h18;
  localparam logic [5:0] OFF_RXDAT = 6'h1C;
  localparam logic [5:0] OFF_TXDAT = 6'h20;

  typedef enum logic [1:0] {RX_IDLE, RX_RECV, RX_DRAIN} rx_state_e;
endpackage

// File: rtl/bpp_regs.sv
module bpp_regs
  import bpp_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          CNT_W  = 11,
  parameter logic [31:0] ID_HI  = 32'h504B5450,
  parameter logic [31:0] ID_LO  = 32'h4F525430
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        ctl_bits,   // {wdata[31], wdata[1:0]}
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [7:0]        rx_byte,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              irq,
  output logic              soft_rst,
  output logic              rx_pop,
  output logic              txcnt_wr,
  output logic              txdat_wr
);
  logic [5:0] off;
  logic       unused_hi;
  logic       ctl_wr, ctl_rd;
  logic [2:0] ictl, ictl_n;     // {test, rx_done, tx_done}
  logic       busy_n;

  assign off       = bus_addr[5:0];
  assign unused_hi = ^bus_addr[ADDR_W-1:6];
  assign ctl_wr    = bus_wr && (off == OFF_ICTL);
  assign ctl_rd    = bus_rd && !bus_wr && (off == OFF_ICTL);
  assign soft_rst  = ctl_wr && (ctl_bits[1:0] == 2'b00) && ctl_bits[2];
  assign rx_pop    = bus_rd && !bus_wr && (off == OFF_RXDAT) && (rx_count != '0);
  assign txcnt_wr  = bus_wr && (off == OFF_TXCNT);
  assign txdat_wr  = bus_wr && (off == OFF_TXDAT);
  assign irq       = |ictl;

  always_comb begin
    ictl_n = ictl;
    busy_n = busy;
    if (ctl_wr) begin
      if (ctl_bits[0])      ictl_n[0] = 1'b0;
      else if (ctl_bits[1]) ictl_n[1] = 1'b0;
      else if (ctl_bits[2]) ictl_n = 3'b100;
    end else if (ctl_rd) begin
      ictl_n[2] = 1'b0;
    end
    if (!soft_rst) begin
      if (rx_done) ictl_n[1] = 1'b1;
      if (tx_done) ictl_n[0] = 1'b1;
    end
    if (soft_rst)                busy_n = 1'b1;
    else if (ctl_wr)             busy_n = |ictl_n;
    if (rx_done || tx_done)      busy_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ictl <= '0;
      busy <= 1'b1;
    end else begin
      ictl <= ictl_n;
      busy <= busy_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (off)
        OFF_ID0:   bus_rdata = ID_HI;
        OFF_ID1:   bus_rdata = ID_LO;
        OFF_BUSY:  bus_rdata = {31'd0, busy};
        OFF_RXCNT: bus_rdata = 32'(rx_count);
        OFF_TXCNT: bus_rdata = 32'(tx_count);
        OFF_ICTL:  bus_rdata = {ictl[2], 29'd0, ictl[1:0]};
        OFF_INFO:  bus_rdata = '0;
        OFF_RXDAT: bus_rdata = (rx_count != '0) ? {24'd0, rx_byte} : '0;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bpp_rx.sv
module bpp_rx
  import bpp_pkg::*;
#(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             soft_rst,
  input  logic             rx_pop,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             rx_done,
  output logic [CNT_W-1:0] rx_count,
  output logic [7:0]       rx_byte
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(FRAME_MAX);

  rx_state_e        state, state_n;
  logic [CNT_W-1:0] wr_idx, wr_idx_n, idx, rd_ptr;
  logic [7:0]       mem [FRAME_MAX];
  logic             beat, at_cap, store, done_raw;

  assign s_ready = ((state == RX_IDLE) && !busy && (rx_count < MAX_C)) ||
                   (state == RX_RECV) || (state == RX_DRAIN);

  always_comb begin
    beat     = s_valid && s_ready;
    idx      = (state == RX_IDLE) ? '0 : wr_idx;
    at_cap   = (idx == MAX_C - 1'b1);
    store    = beat && (state != RX_DRAIN) && !at_cap;
    done_raw = store && s_last;
    state_n  = state;
    wr_idx_n = wr_idx;
    if (beat) begin
      case (state)
        RX_IDLE, RX_RECV: begin
          if (s_last)      state_n = RX_IDLE;
          else if (at_cap) state_n = RX_DRAIN;
          else begin
            state_n  = RX_RECV;
            wr_idx_n = idx + 1'b1;
          end
        end
        default: if (s_last) state_n = RX_IDLE;
      endcase
    end
    if (soft_rst && (state_n == RX_RECV)) state_n = RX_DRAIN;
  end

  assign rx_done = done_raw && !soft_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      wr_idx   <= '0;
      rx_count <= '0;
      rd_ptr   <= '0;
    end else begin
      state  <= state_n;
      wr_idx <= wr_idx_n;
      if (soft_rst) begin
        rx_count <= '0;
        rd_ptr   <= '0;
      end else if (rx_done) begin
        rx_count <= idx + 1'b1;
        rd_ptr   <= '0;
      end else if (rx_pop) begin
        rx_count <= rx_count - 1'b1;
        rd_ptr   <= rd_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[idx] <= s_data;
  end

  assign rx_byte = mem[rd_ptr];
endmodule

// File: rtl/bpp_tx.sv
module bpp_tx #(
  parameter int FRAME_MAX = 1514,
  parameter int CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             txcnt_wr,
  input  logic             txdat_wr,
  input  logic [31:0]      wdata,
  input  logic             m_ready,
  output logic             m_valid,
  output logic [7:0]       m_data,
  output logic             m_last,
  output logic             tx_done,
  output logic [CNT_W-1:0] tx_count
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(FRAME_MAX);

  logic [CNT_W-1:0] wptr, wptr_n, oidx, olen;
  logic [7:0]       mem [FRAME_MAX];
  logic             active, wr_ok, send;

  assign wr_ok   = txdat_wr && !active;
  assign wptr_n  = wptr + 1'b1;
  assign send    = wr_ok && ((wptr_n == tx_count) || (wptr_n == MAX_C));
  assign tx_done = send;
  assign m_valid = active;
  assign m_data  = mem[oidx];
  assign m_last  = active && (oidx == olen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_count <= '0;
      wptr     <= '0;
      active   <= 1'b0;
      oidx     <= '0;
      olen     <= '0;
    end else begin
      if (soft_rst) begin
        tx_count <= '0;
        wptr     <= '0;
      end else if (txcnt_wr) begin
        tx_count <= (wdata <= 32'(FRAME_MAX)) ? wdata[CNT_W-1:0] : '0;
        wptr     <= '0;
      end else if (send) begin
        tx_count <= '0;
        wptr     <= '0;
      end else if (wr_ok) begin
        wptr <= wptr_n;
      end
      if (send) begin
        active <= 1'b1;
        oidx   <= '0;
        olen   <= wptr_n;
      end else if (active && m_ready) begin
        if (m_last) active <= 1'b0;
        else        oidx   <= oidx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata[7:0];
  end
endmodule

// File: rtl/byte_pkt_port.sv
module byte_pkt_port
  import bpp_pkg::*;
#(
  parameter int FRAME_MAX = FRAME_MAX_DEF,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq
);
  localparam int CNT_W = $clog2(FRAME_MAX + 1);

  logic             busy_w, soft_rst_w, rx_pop_w, txcnt_wr_w, txdat_wr_w;
  logic             rx_done_w, tx_done_w;
  logic [CNT_W-1:0] rx_cnt_w, tx_cnt_w;
  logic [7:0]       rx_byte_w;

  bpp_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .ctl_bits({bus_wdata[31], bus_wdata[1:0]}),
    .rx_done(rx_done_w), .tx_done(tx_done_w), .rx_count(rx_cnt_w),
    .tx_count(tx_cnt_w), .rx_byte(rx_byte_w), .bus_rdata(bus_rdata),
    .busy(busy_w), .irq(irq), .soft_rst(soft_rst_w), .rx_pop(rx_pop_w),
    .txcnt_wr(txcnt_wr_w), .txdat_wr(txdat_wr_w)
  );

  bpp_rx #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .soft_rst(soft_rst_w),
    .rx_pop(rx_pop_w), .s_valid(rx_valid), .s_data(rx_data), .s_last(rx_last),
    .s_ready(rx_ready), .rx_done(rx_done_w), .rx_count(rx_cnt_w),
    .rx_byte(rx_byte_w)
  );

  bpp_tx #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_w), .txcnt_wr(txcnt_wr_w),
    .txdat_wr(txdat_wr_w), .wdata(bus_wdata), .m_ready(tx_ready),
    .m_valid(tx_valid), .m_data(tx_data), .m_last(tx_last),
    .tx_done(tx_done_w), .tx_count(tx_cnt_w)
  );
endmodule

// File: rtl/bpp_checker.sv
module bpp_checker
  import bpp_pkg::*;
#(
  parameter int FRAME_MAX = 1514,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              busy,
  input logic              rx_done,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [CNT_W-1:0]  tx_cnt
);
  // R5: busy only falls when every interrupt flag is clear
  assert_irq_implies_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_tx_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  assert_rx_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr[5:0] == OFF_RXDAT && rx_cnt != '0 && !rx_done)
      |=> (rx_cnt == $past(rx_cnt) - 1'b1));

  assert_txcnt_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[5:0] == OFF_TXCNT && bus_wdata > 32'(FRAME_MAX))
      |=> (tx_cnt == '0));

  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[5:0] == OFF_ICTL && bus_wdata[1:0] == 2'b00 && bus_wdata[31])
      |=> (irq && busy && rx_cnt == '0 && tx_cnt == '0));
endmodule

bind byte_pkt_port bpp_checker #(.FRAME_MAX(FRAME_MAX), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .busy(busy_w), .rx_done(rx_done_w),
  .rx_cnt(rx_cnt_w), .tx_cnt(tx_cnt_w)
);

// File: tb/byte_pkt_port_test.sv
module byte_pkt_port_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        rx_valid = 0, rx_ready, rx_last = 0;
  logic [7:0]  rx_data = 0;
  logic        tx_valid, tx_ready = 0, tx_last;
  logic [7:0]  tx_data;
  logic        irq;

  int total = 0, fails = 0;
  logic [7:0] exp_tx [0:2047];
  logic [7:0] got_tx [0:2047];

  always #4 clk = ~clk;

  byte_pkt_port uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'(i * 13 + s * 7 + 5);
  endfunction

  task automatic send_rx(input int len, input int s, output int stalls);
    stalls = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = pat(i, s); rx_last = (i == len - 1);
      #1;
      while (!rx_ready) begin stalls++; @(negedge clk); #1; end
      @(posedge clk);
    end
    #1 rx_valid = 0; rx_last = 0;
  endtask

  task automatic collect_tx(input bit rnd, output int n);
    bit done = 0;
    n = 0;
    while (!done) begin
      @(negedge clk); tx_ready = rnd ? 1'($urandom % 2) : 1'b1;
      #1;
      if (tx_valid && tx_ready) begin
        got_tx[n] = tx_data; n++;
        if (tx_last) done = 1;
      end
      @(posedge clk);
    end
    #1 tx_ready = 0;
  endtask

  task automatic tx_frame_check(input string req, input int n, input bit rnd);
    int got, mism;
    collect_tx(rnd, got);
    chk({req, " length"}, got, n);
    mism = 0;
    for (int i = 0; i < n; i++) if (got_tx[i] !== exp_tx[i]) mism++;
    chk({req, " bytes"}, mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int st, n;
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R2 reset state
    rd_chk("R2 busy", 8'h08, 1);
    rd_chk("R2 rxcnt", 8'h0C, 0);
    rd_chk("R2 txcnt", 8'h10, 0);
    rd_chk("R2 ictl", 8'h14, 0);
    chk("R2 irq", irq, 0);

    // R1 decode
    rd_chk("R1 id0", 8'h00, 32'h504B5450);
    rd_chk("R1 id1", 8'h04, 32'h4F525430);
    rd_chk("R1 alias", 8'h40, 32'h504B5450);
    rd_chk("R1 info", 8'h18, 0);
    rd_chk("R1 unmapped", 8'h24, 0);
    rd_chk("R1 txdat reads 0", 8'h20 + 8'h40, 0);
    wr(8'h0C, 32'd5);
    wr(8'h08, 32'd0);
    rd_chk("R1 rxcnt ro", 8'h0C, 0);
    rd_chk("R1 busy ro", 8'h08, 1);

    // R7 blocked while busy
    @(negedge clk); rx_valid = 1; rx_data = 8'h11; rx_last = 1;
    repeat (3) begin #1 chk("R7 ready low when busy", rx_ready, 0); @(negedge clk); end
    rx_valid = 0; rx_last = 0;

    // R5 write zero -> busy follows OR (0)
    wr(8'h14, 0);
    rd_chk("R5 busy after ack", 8'h08, 0);

    // R7/R9 random frames
    for (int k = 0; k < 3; k++) begin
      int len = 1 + int'($urandom % 60);
      send_rx(len, k, st);
      chk("R7 no stall", st, 0);
      rd_chk("R7 rxcnt", 8'h0C, len);
      rd_chk("R7 ictl rx bit", 8'h14, 2);
      chk("R3 irq", irq, 1);
      rd_chk("R7 busy", 8'h08, 1);
      chk("R7 ready low after frame", rx_ready, 0);
      for (int i = 0; i < len; i++) rd_chk("R9 byte", 8'h1C, {24'd0, pat(i, k)});
      rd_chk("R9 count zero", 8'h0C, 0);
      rd_chk("R9 empty read", 8'h1C, 0);
      rd_chk("R9 count stays", 8'h0C, 0);
      wr(8'h14, 2);
      chk("R3 irq cleared", irq, 0);
      rd_chk("R5 busy cleared", 8'h08, 0);
    end

    // R8 long frames
    send_rx(1514, 9, st);
    chk("R8 drain no stall 1514", st, 0);
    rd_chk("R8 rxcnt 1514", 8'h0C, 0);
    send_rx(1600, 8, st);
    chk("R8 drain no stall 1600", st, 0);
    rd_chk("R8 rxcnt 1600", 8'h0C, 0);
    rd_chk("R8 ictl", 8'h14, 0);
    rd_chk("R8 busy", 8'h08, 0);
    send_rx(1513, 3, st);
    rd_chk("R7 max frame", 8'h0C, 1513);
    rd_chk("R9 first of max", 8'h1C, {24'd0, pat(0, 3)});
    rd_chk("R9 count dec", 8'h0C, 1512);

    // R10 clamp
    wr(8'h10, 1515);  rd_chk("R10 over", 8'h10, 0);
    wr(8'h10, 1514);  rd_chk("R10 at max", 8'h10, 1514);
    wr(8'h10, 32'h8000_0005); rd_chk("R10 huge", 8'h10, 0);

    // R11/R12 random transmit
    n = 2 + int'($urandom % 30);
    wr(8'h10, n);
    for (int i = 0; i < n; i++) begin
      exp_tx[i] = 8'($urandom);
      wr(8'h20, {24'hABCDEF, exp_tx[i]});
      if (i == n - 2) begin
        chk("R11 no send early", tx_valid, 0);
        rd_chk("R11 count held", 8'h10, n);
      end
    end
    chk("R11 sending", tx_valid, 1);
    rd_chk("R11 count cleared", 8'h10, 0);
    rd_chk("R11 ictl both", 8'h14, 3);
    tx_frame_check("R12 random ready", n, 1);

    // R5 priority
    wr(8'h14, 3);
    rd_chk("R5 tx first", 8'h14, 2);
    rd_chk("R5 busy or", 8'h08, 1);
    wr(8'h14, 32'h8000_0002);
    rd_chk("R5 rx before test", 8'h14, 0);
    rd_chk("R5 busy zero", 8'h08, 0);
    rd_chk("R5 no soft reset", 8'h0C, 1512);

    // R12 writes ignored while draining
    wr(8'h10, 3);
    for (int i = 0; i < 3; i++) begin exp_tx[i] = 8'(8'h30 + i); wr(8'h20, exp_tx[i]); end
    wr(8'h10, 2);
    wr(8'h20, 8'hAA); wr(8'h20, 8'hBB);
    tx_frame_check("R12 first frame", 3, 0);
    @(negedge clk); chk("R12 ignored writes sent nothing", tx_valid, 0);
    exp_tx[0] = 8'hCC; exp_tx[1] = 8'hDD;
    wr(8'h20, 8'hCC); wr(8'h20, 8'hDD);
    tx_frame_check("R12 second frame", 2, 1);
    wr(8'h14, 1);
    rd_chk("R5 ack tx", 8'h14, 0);

    // R6 soft reset and R4 test bit
    send_rx(4, 5, st);
    wr(8'h10, 7);
    wr(8'h14, 32'h8000_0000);
    chk("R6 irq", irq, 1);
    rd_chk("R6 rxcnt", 8'h0C, 0);
    rd_chk("R6 txcnt", 8'h10, 0);
    rd_chk("R4 ictl test", 8'h14, 32'h8000_0000);
    chk("R4 irq after read", irq, 0);
    rd_chk("R4 ictl cleared", 8'h14, 0);
    rd_chk("R4 busy kept", 8'h08, 1);
    wr(8'h14, 0);
    rd_chk("R6 busy released", 8'h08, 0);

    // R11 count zero -> send at 1514
    for (int i = 0; i < 1514; i++) begin
      exp_tx[i] = 8'(i * 3);
      wr(8'h20, exp_tx[i]);
      if (i == 1512) chk("R11 no send at 1513", tx_valid, 0);
    end
    chk("R11 sent at 1514", tx_valid, 1);
    tx_frame_check("R11 full frame", 1514, 0);
    rd_chk("R11 ictl tx", 8'h14, 1);

    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule